// File: doc/BRIEF.md
# Threshold FIFO DMA Request Generator

This block produces the DMA request line for a small data FIFO that sits between a disk-side byte stream and a host DMA controller while a transfer runs. In read direction the disk side pushes bytes and the host drains them. In write direction the host fills the FIFO and the disk side consumes it. A host byte moves on every clock in which the active-low acknowledge is held low. No address decode is involved.

A configuration load strobe captures three settings and starts a new transfer phase. The first setting picks FIFO mode or byte mode. In byte mode the buffer holds one byte and every byte gets its own request. The second is a 4-bit threshold field. The third is an active-low burst select. In single style the request drops after each acknowledged byte. In burst style it is held across acknowledges until the FIFO runs empty on reads or full on writes. An acknowledged byte that carries terminal count ends the phase. A sticky flag records any disk-side push into a full buffer or pop from an empty one.

Top module: `dmaq_req_gen`

## Requirements
- R1: After reset `drq` and `overrun` are 0. Byte mode is selected, and the burst select reads as 1, which means single style.
- R2: In FIFO mode with read direction (`dir_rd`=1), `drq` rises at the clock edge where the fill level reaches `cfg_thr`+1. It stays low while the level is below that.
- R3: In FIFO mode with write direction (`dir_rd`=0), `drq` rises at the edge where the free space (16 minus the fill level) reaches `cfg_thr`+1. It stays low while the free space is smaller.
- R4: With `cfg_burst_n`=1, an acknowledged cycle (`dack_n`=0 while `drq`=1) drops `drq` at the next edge. If the level condition still holds afterwards, `drq` rises again one edge later.
- R5: With `cfg_burst_n`=0, `drq` stays high across acknowledged and idle cycles. It falls at the edge where an acknowledge empties the FIFO (read) or fills it (write).
- R6: Bytes leave the FIFO in the order they entered, on `host_rdata` for reads and on `disk_rdata` for writes. In both cases the output shows the oldest byte during the cycle it is taken.
- R7: A cycle with `dack_n`=0 and `tc`=1 forces `drq` low at the next edge. `drq` then stays low, whatever the fill level, until the next `cfg_load`.
- R8: A `disk_push` into a full buffer in read direction, or a `disk_pop` from an empty buffer in write direction, sets `overrun`. The rejected byte is discarded. `overrun` stays set until reset.
- R9: A host access happens on every cycle with `dack_n`=0, even while `drq` is low.
- R10: `cfg_load` empties the FIFO and re-arms request generation after a terminal count.
- R11: In byte mode the buffer capacity is 1 byte and the threshold is 1. `cfg_thr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Captures the configuration, flushes the FIFO, re-arms the request |
| cfg_fifo_on | input | 1 | 1 = FIFO mode, 0 = byte mode |
| cfg_thr | input | 4 | Threshold field; service level is this value plus one |
| cfg_burst_n | input | 1 | 0 = burst style, 1 = single style |
| dir_rd | input | 1 | 1 = read (disk to host), 0 = write (host to disk) |
| dack_n | input | 1 | Active-low DMA acknowledge; each low cycle moves one host byte |
| tc | input | 1 | Terminal count, qualified by `dack_n` low |
| host_wdata | input | 8 | Host byte written on write-direction acknowledges |
| host_rdata | output | 8 | Oldest FIFO byte, taken by the host on read-direction acknowledges |
| disk_push | input | 1 | Disk side pushes `disk_wdata` (read direction) |
| disk_wdata | input | 8 | Disk-side byte to push |
| disk_pop | input | 1 | Disk side takes `disk_rdata` (write direction) |
| disk_rdata | output | 8 | Oldest FIFO byte for the disk side |
| drq | output | 1 | Registered DMA request |
| overrun | output | 1 | Sticky disk-side overflow or underrun flag |

## Verification
Reads are run with the FIFO filled one byte at a time. This shows whether the request rises at exactly threshold-plus-one, or one byte early or late. Writes are run from full while the disk side drains. This checks that the free-space test is used rather than the fill level. Single-style runs keep enough data to re-request, so the one-cycle release separates single behaviour from burst behaviour. Burst runs insert an idle cycle in the middle and then stop on the empty or full boundary. Further patterns cover stray acknowledges while the request is low, a terminal count followed by a reload, and byte mode with the largest threshold field.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,
    RQ_ON   = 2'd1,
    RQ_DONE = 2'd2
  } rq_state_e;
endpackage

// File: rtl/dmaq_cfg.sv
// Configuration capture: turns the mode bits into an effective capacity
// and service level so the request logic needs no mode knowledge.
module dmaq_cfg #(
  parameter int DEPTH = 16,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CW = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             fifo_on_in,
  input  logic [THR_W-1:0] thr_in,
  input  logic             burst_n_in,
  output logic             single,
  output logic [CW-1:0]    cap,
  output logic [CW-1:0]    thr_eff
);
  always_ff @(posedge clk) begin
    if (rst) begin
      single  <= 1'b1;
      cap     <= CW'(1);
      thr_eff <= CW'(1);
    end else if (load) begin
      single  <= burst_n_in;
      cap     <= fifo_on_in ? CW'(DEPTH) : CW'(1);
      thr_eff <= fifo_on_in ? ({1'b0, thr_in} + CW'(1)) : CW'(1);
    end
  end
endmodule

// File: rtl/dmaq_fifo.sv
// Byte FIFO with a runtime capacity limit (1 or DEPTH). Storage has no
// reset so it maps onto distributed RAM; the read side is show-ahead.
module dmaq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic [CW-1:0] cnt_nxt,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok, pop_ok;

  assign full    = (count == cap);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign cnt_nxt = count + CW'(push_ok) - CW'(pop_ok);
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      count <= cnt_nxt;
    end
  end
endmodule

// File: rtl/dmaq_req_ctl.sv
// Request state machine. Level tests use the post-edge fill count so the
// registered request moves in the same edge as the count.
module dmaq_req_ctl
  import dmaq_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          single,
  input  logic          rd_mode,
  input  logic          host_acc,
  input  logic          tc,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [CW-1:0] cap,
  input  logic [CW-1:0] thr_eff,
  output logic          drq
);
  rq_state_e state, state_nxt;
  logic      lvl_ok, at_end, tc_hit;

  always_comb begin
    if (rd_mode) begin
      lvl_ok = (cnt_nxt >= thr_eff);
      at_end = (cnt_nxt == '0);
    end else begin
      lvl_ok = ((cap - cnt_nxt) >= thr_eff);
      at_end = (cnt_nxt == cap);
    end
  end

  assign tc_hit = host_acc && tc;

  always_comb begin
    state_nxt = state;
    unique case (state)
      RQ_IDLE: begin
        if (tc_hit) state_nxt = RQ_DONE;
        else if (lvl_ok && !host_acc) state_nxt = RQ_ON;
      end
      RQ_ON: begin
        if (tc_hit) state_nxt = RQ_DONE;
        else if (host_acc && (single || at_end)) state_nxt = RQ_IDLE;
      end
      RQ_DONE: state_nxt = RQ_DONE;
      default: state_nxt = RQ_IDLE;
    endcase
    if (flush) state_nxt = RQ_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RQ_IDLE;
      drq   <= 1'b0;
    end else begin
      state <= state_nxt;
      drq   <= (state_nxt == RQ_ON);
    end
  end
endmodule

// File: rtl/dmaq_req_gen.sv
module dmaq_req_gen #(
  parameter int DEPTH = 16,
  parameter int DW = 8,
  localparam int THR_W = $clog2(DEPTH),
  localparam int CW = THR_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic             cfg_fifo_on,
  input  logic [THR_W-1:0] cfg_thr,
  input  logic             cfg_burst_n,
  input  logic             dir_rd,
  input  logic             dack_n,
  input  logic             tc,
  input  logic [DW-1:0]    host_wdata,
  output logic [DW-1:0]    host_rdata,
  input  logic             disk_push,
  input  logic [DW-1:0]    disk_wdata,
  input  logic             disk_pop,
  output logic [DW-1:0]    disk_rdata,
  output logic             drq,
  output logic             overrun
);
  logic          single_w;
  logic [CW-1:0] cap_w, thr_w, fill, fill_nxt;
  logic          full_w, empty_w, host_acc, f_push, f_pop;
  logic [DW-1:0] f_wdata, head;

  assign host_acc = !dack_n;
  assign f_push   = dir_rd ? disk_push : host_acc;
  assign f_pop    = dir_rd ? host_acc : disk_pop;
  assign f_wdata  = dir_rd ? disk_wdata : host_wdata;
  assign host_rdata = head;
  assign disk_rdata = head;

  dmaq_cfg #(.DEPTH(DEPTH)) u_cfg (
    .clk(clk), .rst(rst), .load(cfg_load),
    .fifo_on_in(cfg_fifo_on), .thr_in(cfg_thr), .burst_n_in(cfg_burst_n),
    .single(single_w), .cap(cap_w), .thr_eff(thr_w)
  );

  dmaq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(cfg_load), .cap(cap_w),
    .push(f_push), .pop(f_pop), .wdata(f_wdata), .rdata(head),
    .count(fill), .cnt_nxt(fill_nxt), .full(full_w), .empty(empty_w)
  );

  dmaq_req_ctl #(.CW(CW)) u_ctl (
    .clk(clk), .rst(rst), .flush(cfg_load), .single(single_w),
    .rd_mode(dir_rd), .host_acc(host_acc), .tc(tc),
    .cnt_nxt(fill_nxt), .cap(cap_w), .thr_eff(thr_w), .drq(drq)
  );

  always_ff @(posedge clk) begin
    if (rst) overrun <= 1'b0;
    else if ((dir_rd && disk_push && full_w) || (!dir_rd && disk_pop && empty_w))
      overrun <= 1'b1;
  end
endmodule

// File: rtl/dmaq_req_gen_chk.sv
module dmaq_req_gen_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_load,
  input logic          dack_n,
  input logic          tc,
  input logic          drq,
  input logic          overrun,
  input logic          single_w,
  input logic [CW-1:0] cap_w,
  input logic [CW-1:0] fill
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst |=> (!drq && !overrun));
  // R4
  single_release_chk: assert property (@(posedge clk) disable iff (rst)
    (drq && !dack_n && single_w) |=> !drq);
  // R5
  burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (drq && dack_n && !single_w && !cfg_load) |=> drq);
  // R7
  tc_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (!dack_n && tc) |=> !drq);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
  // R11
  byte_cap_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_w == CW'(1)) |-> (fill <= CW'(1)));
endmodule

bind dmaq_req_gen dmaq_req_gen_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .dack_n(dack_n), .tc(tc),
  .drq(drq), .overrun(overrun), .single_w(single_w), .cap_w(cap_w), .fill(fill)
);

// File: tb/sim_dmaq_req_gen.sv
`timescale 1ns/1ps
module sim_dmaq_req_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_load = 1'b0, cfg_fifo_on = 1'b0, cfg_burst_n = 1'b1;
  logic [3:0] cfg_thr = 4'd0;
  logic       dir_rd = 1'b1, dack_n = 1'b1, tc = 1'b0;
  logic [7:0] host_wdata = 8'h00, disk_wdata = 8'h00;
  logic       disk_push = 1'b0, disk_pop = 1'b0;
  logic [7:0] host_rdata, disk_rdata;
  logic       drq, overrun;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #2.5 clk = ~clk;

  dmaq_req_gen u0 (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_fifo_on(cfg_fifo_on),
    .cfg_thr(cfg_thr), .cfg_burst_n(cfg_burst_n), .dir_rd(dir_rd),
    .dack_n(dack_n), .tc(tc), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .disk_push(disk_push), .disk_wdata(disk_wdata), .disk_pop(disk_pop),
    .disk_rdata(disk_rdata), .drq(drq), .overrun(overrun)
  );

  task automatic chk(string tag, int act, int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(bit fe, logic [3:0] thr, bit bn, bit rd);
    cfg_fifo_on = fe; cfg_thr = thr; cfg_burst_n = bn; dir_rd = rd;
    cfg_load = 1'b1;
    exp_q.delete();
    step();
    cfg_load = 1'b0;
  endtask

  task automatic dpush(logic [7:0] d, bit accepted);
    disk_push = 1'b1; disk_wdata = d;
    if (accepted) exp_q.push_back(d);
    step();
    disk_push = 1'b0;
  endtask

  task automatic dpop();
    disk_pop = 1'b1;
    step();
    disk_pop = 1'b0;
  endtask

  task automatic hack(bit t, logic [7:0] d);
    dack_n = 1'b0; tc = t; host_wdata = d;
    if (!dir_rd) exp_q.push_back(d);
    step();
    dack_n = 1'b1; tc = 1'b0;
  endtask

  // Monitor: compares bytes leaving the FIFO with the scoreboard (R6)
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (dir_rd && !dack_n && exp_q.size() > 0) chk("R6 host_rdata", host_rdata, exp_q.pop_front());
      if (!dir_rd && disk_pop && exp_q.size() > 0) chk("R6 disk_rdata", disk_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1 drq after reset", drq, 0);
    chk("R1 overrun after reset", overrun, 0);
    step();
    chk("R1 idle drq", drq, 0);

    // Byte mode from reset (read): one byte per request, single style
    dpush(8'hA1, 1);
    chk("R11 byte-mode drq at 1 byte", drq, 1);
    hack(0, 8'h00);
    chk("R1 single-style release", drq, 0);
    step();
    chk("R11 empty byte buffer", drq, 0);
    dpush(8'hA2, 1);
    dpush(8'hA3, 0);
    chk("R8 overflow sets flag (cap 1)", overrun, 1);
    hack(0, 8'h00);
    step();
    chk("R8 flag sticky", overrun, 1);

    rst = 1'b1; exp_q.delete(); step(); step(); rst = 1'b0;
    chk("R1 overrun cleared by reset", overrun, 0);

    // R2: read threshold 4
    cfg(1, 4'd3, 1, 1);
    for (int i = 0; i < 3; i++) begin
      dpush(8'h10 + 8'(i), 1);
      chk("R2 below threshold", drq, 0);
    end
    dpush(8'h13, 1);
    chk("R2 at threshold", drq, 1);
    hack(0, 8'h00);
    chk("R4 release on ack", drq, 0);
    step();
    chk("R2 level fell below", drq, 0);
    for (int i = 0; i < 3; i++) hack(0, 8'h00);
    chk("R9 stray acks drained FIFO", exp_q.size(), 0);

    // R4: re-request after single ack
    cfg(1, 4'd0, 1, 1);
    for (int i = 0; i < 3; i++) dpush(8'h20 + 8'(i), 1);
    chk("R4 drq up", drq, 1);
    hack(0, 8'h00);
    chk("R4 dropped", drq, 0);
    step();
    chk("R4 re-raised", drq, 1);
    hack(0, 8'h00); step(); hack(0, 8'h00); step();
    chk("R4 empty no request", drq, 0);

    // R5: burst read of 8
    cfg(1, 4'd7, 0, 1);
    for (int i = 0; i < 8; i++) dpush(8'h30 + 8'(i), 1);
    chk("R5 burst drq up", drq, 1);
    for (int i = 0; i < 7; i++) begin
      hack(0, 8'h00);
      chk("R5 held across ack", drq, 1);
      if (i == 2) begin step(); chk("R5 held idle", drq, 1); end
    end
    hack(0, 8'h00);
    chk("R5 drop at empty", drq, 0);

    // R3/R5: burst write, then drain with disk pops
    cfg(1, 4'd3, 0, 0);
    chk("R10 drq low on load", drq, 0);
    step();
    chk("R3 empty write requests", drq, 1);
    for (int i = 0; i < 16; i++) begin
      hack(0, 8'h40 + 8'(i));
      if (i == 14) chk("R5 held before full", drq, 1);
    end
    chk("R5 drop at full", drq, 0);
    for (int i = 0; i < 3; i++) begin
      dpop();
      chk("R3 free space below threshold", drq, 0);
    end
    dpop();
    chk("R3 free space at threshold", drq, 1);
    for (int i = 0; i < 12; i++) dpop();
    chk("R6 all written bytes popped", exp_q.size(), 0);
    chk("R8 no flag yet", overrun, 0);
    dpop();
    chk("R8 underrun sets flag", overrun, 1);

    // R7/R10: terminal count, then reload
    cfg(1, 4'd0, 0, 0);
    step();
    chk("R7 write request up", drq, 1);
    hack(0, 8'h55);
    chk("R7 burst continues", drq, 1);
    hack(1, 8'h56);
    chk("R7 tc drops drq", drq, 0);
    step(); step();
    chk("R7 stays low after tc", drq, 0);
    cfg(1, 4'd0, 1, 1);
    step();
    chk("R10 flushed FIFO no read request", drq, 0);
    dpush(8'h66, 1);
    chk("R10 re-armed", drq, 1);
    hack(0, 8'h00);

    // R11: byte mode ignores threshold field
    cfg(0, 4'd15, 1, 1);
    dpush(8'h77, 1);
    chk("R11 read byte mode thr ignored", drq, 1);
    hack(0, 8'h00);
    cfg(0, 4'd15, 1, 0);
    step();
    chk("R11 write byte mode request", drq, 1);
    hack(0, 8'h88);
    step();
    chk("R11 byte buffer full", drq, 0);
    dpop();
    chk("R11 re-request after pop", drq, 1);

    step();
    done = 1'b1;
    summary();
  end
endmodule